// File: doc/BRIEF.md
# DDR2 Read Burst Command Legality Monitor

This block sits beside a memory controller and watches, one clock at a time, the commands the controller places on a DDR2-style command bus. It keeps track of the most recent READ: how many clocks ago it was issued, whether it was a four-beat or an eight-beat burst, and whether auto precharge was requested. With this context it judges each new command against the rules that govern read bursts. A four-beat burst may not be cut short. An eight-beat burst may be cut short only by a READ that lands on a four-beat boundary, and only when auto precharge is off. A WRITE must wait until the data of the last READ has left the device.

The monitor never stalls, delays or changes the command stream. It takes one command per clock and has no back-pressure, so the controller is never held off by it. The first violation raises a sticky flag and stores a 3-bit class code. Both stay put until software-independent control logic pulses the synchronous clear. The additive and CAS latencies are static configuration inputs. The read latency is taken as their sum.

Top module: `rd_cmd_legality_chk`

## Requirements
- R1: After a synchronous active-low reset, `err_o` is 0 and `err_code_o` is 0, and no read history is held. A command issued before any READ is never a violation.
- R2: The command encoding on `cmd_i` is 0 = NOP, 1 = READ, 2 = WRITE, 3 = PRECHARGE, 4 = ACTIVATE. Codes 5 to 7 are treated like any other non-READ command. The offset of a command is the number of clocks since the latest READ. Every READ, legal or not, restarts the offset count and replaces the stored burst length and auto-precharge flag.
- R3: After a four-beat READ (`bl8_i` = 0), any non-NOP command at offset 1 is a violation with code 1.
- R4: After an eight-beat READ with auto precharge off, a READ at offset 2 is legal. A READ at offset 1 or 3 is a violation with code 2.
- R5: After an eight-beat READ, any command other than NOP or READ at offsets 1 to 3 is a violation with code 3. This holds whatever the auto-precharge setting.
- R6: A READ issued at an offset exactly equal to half the burst length (2 for four beats, 4 for eight beats) is a legal seamless concatenation.
- R7: After an eight-beat READ with auto precharge on, any READ at offsets 1 to 3 is a violation with code 5.
- R8: Once the burst itself is over, a WRITE at offset k is a violation with code 4 when k < AL + CL + BL/2. It is legal when k is at or beyond that value. BL/2 is 2 or 4.
- R9: `err_o` rises in the clock after the violating command. The first code is held. Later violations change neither the flag nor the code.
- R10: Asserting `clr_i` clears `err_o` and `err_code_o` in the next clock. If a violation occurs in the same clock, the clear wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the error flag and code |
| cmd_i | input | 3 | Command issued this clock (encoding in R2) |
| bl8_i | input | 1 | Burst length of a READ: 1 = eight beats, 0 = four beats |
| ap_i | input | 1 | Auto precharge requested with a READ |
| al_i | input | TIM_W | Additive latency in clocks |
| cl_i | input | TIM_W | CAS latency in clocks |
| err_o | output | 1 | Sticky violation flag |
| err_code_o | output | 3 | Class of the first violation: 0 none, 1 four-beat interrupted, 2 eight-beat bad boundary, 3 eight-beat non-READ interrupt, 4 write too early, 5 auto-precharge burst truncated |

## Verification
The offset counter and the stored burst context drive every decision. An off-by-one in either of them shows at the ports on the first command that sits on a decision edge. Examples are a READ at offset 2 or 3 of an eight-beat burst, or a WRITE exactly at the end of the read data window. In each case `err_o` flips wrongly one clock after that command. A stale burst length or auto-precharge bit left over from an earlier READ shows up in the same way, as a wrong code on the next interruption. The sticky latch, once it is wrong, stays wrong until the next clear. Because of this, the bench compares both outputs after every single clock instead of only at the end of a sequence.

// File: rtl/rdchk_pkg.sv
package rdchk_pkg;

  // command bus encoding
  localparam logic [2:0] CMD_NOP   = 3'd0;
  localparam logic [2:0] CMD_READ  = 3'd1;
  localparam logic [2:0] CMD_WRITE = 3'd2;

  // half burst lengths in command clocks and the legal split point
  localparam int HALF_BL4  = 2;
  localparam int HALF_BL8  = 4;
  localparam int BL8_SPLIT = 2;

  typedef enum logic [2:0] {
    ERR_NONE      = 3'd0,
    ERR_BL4_INT   = 3'd1,
    ERR_BL8_BOUND = 3'd2,
    ERR_BL8_NONRD = 3'd3,
    ERR_WR_EARLY  = 3'd4,
    ERR_AP_TRUNC  = 3'd5
  } err_e;

  // context of the latest READ
  typedef struct packed {
    logic seen;
    logic bl8;
    logic ap;
  } rd_ctx_t;

endpackage

// File: rtl/rdchk_tracker.sv
module rdchk_tracker
  import rdchk_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       cmd_i,
  input  logic             bl8_i,
  input  logic             ap_i,
  output rd_ctx_t          ctx_o,
  output logic [CNT_W-1:0] since_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  rd_ctx_t          ctx_q;
  logic [CNT_W-1:0] since_q;

  // offset counts clocks since the latest READ and saturates well past any window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_q   <= '0;
      since_q <= '0;
    end else if (cmd_i == CMD_READ) begin
      ctx_q.seen <= 1'b1;
      ctx_q.bl8  <= bl8_i;
      ctx_q.ap   <= ap_i;
      since_q    <= CNT_ONE;
    end else if (ctx_q.seen && (since_q != CNT_MAX)) begin
      since_q <= since_q + CNT_ONE;
    end
  end

  assign ctx_o   = ctx_q;
  assign since_o = since_q;

endmodule

// File: rtl/rdchk_rules.sv
module rdchk_rules
  import rdchk_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int TIM_W = 4
) (
  input  logic [2:0]       cmd_i,
  input  rd_ctx_t          ctx_i,
  input  logic [CNT_W-1:0] since_i,
  input  logic [TIM_W-1:0] al_i,
  input  logic [TIM_W-1:0] cl_i,
  output err_e             viol_o
);

  localparam logic [CNT_W-1:0] HALF4 = CNT_W'(HALF_BL4);
  localparam logic [CNT_W-1:0] HALF8 = CNT_W'(HALF_BL8);
  localparam logic [CNT_W-1:0] SPLIT = CNT_W'(BL8_SPLIT);

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] win_end;
  logic             in_burst;
  logic             in_window;
  logic             is_nop;
  logic             is_read;

  always_comb begin
    half      = ctx_i.bl8 ? HALF8 : HALF4;
    win_end   = CNT_W'(al_i) + CNT_W'(cl_i) + half;
    in_burst  = ctx_i.seen && (since_i < half);
    in_window = ctx_i.seen && (since_i < win_end);
    is_nop    = (cmd_i == CMD_NOP);
    is_read   = (cmd_i == CMD_READ);
  end

  // burst occupancy rules take precedence over the write data-window rule
  always_comb begin
    viol_o = ERR_NONE;
    if (!is_nop) begin
      if (in_burst) begin
        if (!ctx_i.bl8) begin
          viol_o = ERR_BL4_INT;
        end else if (!is_read) begin
          viol_o = ERR_BL8_NONRD;
        end else if (ctx_i.ap) begin
          viol_o = ERR_AP_TRUNC;
        end else if (since_i != SPLIT) begin
          viol_o = ERR_BL8_BOUND;
        end
      end else if ((cmd_i == CMD_WRITE) && in_window) begin
        viol_o = ERR_WR_EARLY;
      end
    end
  end

endmodule

// File: rtl/rdchk_err_latch.sv
module rdchk_err_latch
  import rdchk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  err_e viol_i,
  output logic err_o,
  output err_e code_o
);

  logic err_q;
  err_e code_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i) begin
      err_q  <= 1'b0;
      code_q <= ERR_NONE;
    end else if (!err_q && (viol_i != ERR_NONE)) begin
      err_q  <= 1'b1;
      code_q <= viol_i;
    end
  end

  assign err_o  = err_q;
  assign code_o = code_q;

endmodule

// File: rtl/rd_cmd_legality_chk.sv
module rd_cmd_legality_chk
  import rdchk_pkg::*;
#(
  parameter int TIM_W = 4,
  parameter int CNT_W = TIM_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [2:0]       cmd_i,
  input  logic             bl8_i,
  input  logic             ap_i,
  input  logic [TIM_W-1:0] al_i,
  input  logic [TIM_W-1:0] cl_i,
  output logic             err_o,
  output logic [2:0]       err_code_o
);

  rd_ctx_t          ctx;
  logic [CNT_W-1:0] since;
  err_e             viol;
  err_e             code;

  rdchk_tracker #(.CNT_W(CNT_W)) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_i   (cmd_i),
    .bl8_i   (bl8_i),
    .ap_i    (ap_i),
    .ctx_o   (ctx),
    .since_o (since)
  );

  rdchk_rules #(.CNT_W(CNT_W), .TIM_W(TIM_W)) u_rules (
    .cmd_i   (cmd_i),
    .ctx_i   (ctx),
    .since_i (since),
    .al_i    (al_i),
    .cl_i    (cl_i),
    .viol_o  (viol)
  );

  rdchk_err_latch u_latch (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr_i),
    .viol_i (viol),
    .err_o  (err_o),
    .code_o (code)
  );

  assign err_code_o = code;

endmodule

// File: rtl/rdchk_props.sv
module rdchk_props (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_i,
  input logic [2:0] cmd_i,
  input logic       bl8_i,
  input logic       ap_i,
  input logic       err_o,
  input logic [2:0] err_code_o
);

  // R3
  bl4_cut_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cmd_i == 3'd1 && !bl8_i) && (cmd_i != 3'd0) && !err_o && !clr_i)
    |=> (err_o && (err_code_o == 3'd1)));

  // R4
  bl8_split_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(cmd_i == 3'd1 && bl8_i && !ap_i, 2) && ($past(cmd_i) == 3'd0)
     && (cmd_i == 3'd1) && !err_o)
    |=> !err_o);

  // R9
  first_code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !clr_i) |=> (err_o && $stable(err_code_o)));

  // R10
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!err_o && (err_code_o == 3'd0)));

  // R9
  flag_code_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ((err_code_o != 3'd0) && (err_code_o <= 3'd5)));

endmodule

bind rd_cmd_legality_chk rdchk_props u_props (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .cmd_i      (cmd_i),
  .bl8_i      (bl8_i),
  .ap_i       (ap_i),
  .err_o      (err_o),
  .err_code_o (err_code_o)
);

// File: tb/test_rd_cmd_legality_chk.sv
module test_rd_cmd_legality_chk;

  localparam int CLK_PERIOD = 10;
  localparam int TIM_W      = 4;
  localparam int SAT        = 63;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr_i = 1'b0;
  logic [2:0]       cmd_i = 3'd0;
  logic             bl8_i = 1'b0;
  logic             ap_i = 1'b0;
  logic [TIM_W-1:0] al_i = '0;
  logic [TIM_W-1:0] cl_i = 4'd3;
  logic             err_o;
  logic [2:0]       err_code_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // reference model state
  bit m_seen, m_bl8, m_ap, m_err;
  int m_since, m_code;

  rd_cmd_legality_chk #(.TIM_W(TIM_W)) i_rd_cmd_legality_chk (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .cmd_i(cmd_i), .bl8_i(bl8_i),
    .ap_i(ap_i), .al_i(al_i), .cl_i(cl_i), .err_o(err_o), .err_code_o(err_code_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // expected violation class for a command, from the requirements
  function automatic int exp_viol(int cmd, int al, int cl);
    int half;
    half = m_bl8 ? 4 : 2;
    if (cmd == 0 || !m_seen) return 0;                     // R1
    if (m_since < half) begin
      if (!m_bl8) return 1;                                // R3
      if (cmd != 1) return 3;                              // R5
      if (m_ap) return 5;                                  // R7
      return (m_since == 2) ? 0 : 2;                       // R4
    end
    if (cmd == 2 && m_since < al + cl + half) return 4;    // R8
    return 0;                                              // R6
  endfunction

  task automatic check(string tag);
    n_cmp++;
    if (err_o !== m_err || err_code_o !== 3'(m_code)) begin
      n_bad++;
      $display("FAIL %s: err_o=%0b code=%0d expected err=%0b code=%0d",
               tag, err_o, err_code_o, m_err, m_code);
    end
  endtask

  task automatic step(int cmd, bit bl8, bit ap, bit clr, string tag);
    int v;
    @(negedge clk);
    cmd_i = 3'(cmd); bl8_i = bl8; ap_i = ap; clr_i = clr;
    v = exp_viol(cmd, int'(al_i), int'(cl_i));
    if (clr) begin m_err = 0; m_code = 0; end               // R10
    else if (!m_err && v != 0) begin m_err = 1; m_code = v; end  // R9
    if (cmd == 1) begin m_seen = 1; m_since = 1; m_bl8 = bl8; m_ap = ap; end  // R2
    else if (m_seen && m_since < SAT) m_since++;
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic nops(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    m_seen = 0; m_bl8 = 0; m_ap = 0; m_err = 0; m_since = 0; m_code = 0;
    repeat (3) @(posedge clk);
    #1 check("R1 reset state");
    @(negedge clk) rst_n = 1'b1;

    // R1: no history, no violation
    step(2, 0, 0, 0, "R1 write without history");
    step(3, 0, 0, 0, "R1 precharge without history");

    // R3: four-beat cut short
    step(1, 0, 0, 0, "R3 read bl4");
    step(3, 0, 0, 0, "R3 precharge at offset 1");
    step(0, 0, 0, 1, "R10 clear");
    // R2: unlisted code acts as a non-read command
    step(1, 0, 0, 0, "R2 read bl4");
    step(6, 0, 0, 0, "R2 code 6 at offset 1");
    step(0, 0, 0, 1, "R10 clear");

    // R6: seamless concatenation
    step(1, 0, 0, 0, "R6 read bl4");
    step(0, 0, 0, 0, "R6 nop");
    step(1, 1, 0, 0, "R6 read at offset 2 of bl4");
    nops(3, "R6 nop");
    step(1, 1, 1, 0, "R6 read at offset 4 of bl8");
    nops(10, "R6 drain");

    // R4: eight-beat boundary
    step(1, 1, 0, 0, "R4 read bl8");
    step(0, 0, 0, 0, "R4 nop");
    step(1, 1, 0, 0, "R4 read at offset 2 legal");
    step(1, 0, 0, 0, "R4 read at offset 1");
    step(0, 0, 0, 1, "R10 clear");
    step(1, 1, 0, 0, "R4 read bl8");
    nops(2, "R4 nop");
    step(1, 0, 0, 0, "R4 read at offset 3");
    step(0, 0, 0, 1, "R10 clear");

    // R5: non-read inside eight-beat burst
    step(1, 1, 1, 0, "R5 read bl8 ap");
    step(0, 0, 0, 0, "R5 nop");
    step(4, 0, 0, 0, "R5 activate at offset 2");
    step(0, 0, 0, 1, "R10 clear");

    // R7: auto-precharge burst truncated
    step(1, 1, 1, 0, "R7 read bl8 ap");
    step(0, 0, 0, 0, "R7 nop");
    step(1, 0, 0, 0, "R7 read at offset 2");
    // R9: later violation does not overwrite
    step(3, 0, 0, 0, "R9 second violation ignored");
    step(0, 0, 0, 1, "R10 clear");

    // R8: write window with AL=1, CL=3, BL4 -> end at 6
    al_i = 4'd1; cl_i = 4'd3;
    nops(8, "R8 settle");
    step(1, 0, 0, 0, "R8 read bl4");
    nops(4, "R8 nop");
    step(2, 0, 0, 0, "R8 write at offset 5");
    step(0, 0, 0, 1, "R10 clear");
    step(1, 0, 0, 0, "R8 read bl4");
    nops(5, "R8 nop");
    step(2, 0, 0, 0, "R8 write at offset 6 legal");

    // R10: clear wins over a simultaneous violation
    step(1, 0, 0, 0, "R10 read bl4");
    step(3, 0, 0, 1, "R10 clear with violation");
    step(0, 0, 0, 0, "R10 stays clear");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r, c;
      if (i % 500 == 0) begin
        nops(12, "R8 random settle");
        al_i = 4'($urandom % 6); cl_i = 4'(3 + $urandom % 4);
      end
      r = $urandom % 16;
      if (r < 7) c = 0;
      else if (r < 11) c = 1;
      else if (r == 11 || r == 12) c = 2;
      else if (r == 13) c = 3;
      else if (r == 14) c = 4;
      else c = 5 + $urandom % 3;
      step(c, 1'($urandom % 2), ($urandom % 4) == 0, ($urandom % 20) == 0,
           "R9 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule